// File: doc/BRIEF.md
# Operand-Waiting Station Pool

This block is a small pool of instruction-holding stations placed in front of one functional unit of an out-of-order core, such as an adder. Each instruction accepted from the in-order issue stage lands in a free station along with its operation code. For each of its two sources the station gets either the operand value or the tag of the producer that will compute that value later. While an operand is still missing, the station watches a shared result bus. It captures the data whose tag matches the missing operand. One result can complete operands in any number of stations in the same cycle.

A station whose two operands are both present is offered to the functional unit. When several stations are ready at once, the one issued earliest goes first. The unit takes at most one station per cycle, through a valid/ready handshake. The station stays occupied while the unit works. The unit's result later appears on the shared bus with that station's own tag, and the station is then released for reuse. Station `i` owns tag `TAG_BASE + i`. Tag value zero is reserved and means "no producer".

Top module: `rsv_pool`

## Requirements
- R1: After reset, all stations are free: `pool_full` is 0 and `disp_valid` is 0.
- R2: Issue is accepted when `iss_valid` is 1 and `pool_full` is 0. The instruction goes into the lowest-numbered free station. `pool_full` is 1 while every station is occupied. An issue attempt while `pool_full` is 1 is dropped and changes nothing. A full pool stays full in any cycle without a broadcast.
- R3: A source tag of 0 at issue marks the value supplied with it as valid. A nonzero tag marks the operand as waiting, and the station is not offered while any operand waits.
- R4: A broadcast has `bc_valid` = 1 and a nonzero `bc_tag`. It writes `bc_data` into every waiting operand, in any station, whose tag equals `bc_tag`, and marks that operand valid. Operands waiting on other tags are unaffected.
- R5: Suppose an issue is accepted in the same cycle as a broadcast whose tag equals a nonzero source tag of that issue. The station then stores the broadcast data for that operand as valid, instead of the tag.
- R6: A station whose operands are both valid is offered (`disp_valid` = 1) from the cycle after its last operand became valid. The offer presents its operation code on `disp_op` and its own tag `TAG_BASE + index` on `disp_tag`.
- R7: Among offered stations, the one issued earliest is presented. A station is taken when `disp_valid` and `disp_ready` are both 1 at a clock edge, at most one per cycle. While `disp_ready` is 0, the offer is held.
- R8: A taken station is not offered again and stays occupied. A broadcast carrying its own tag frees it, and from the next cycle it counts as free for `pool_full` and for allocation.
- R9: `disp_a` carries the first source operand and `disp_b` the second, in issue order of the two fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| iss_valid | input | 1 | Issue request |
| iss_op | input | OP_W | Operation code of the issued instruction |
| iss_j_tag | input | TAG_W | Producer tag of the first source, 0 if the value is given |
| iss_j_val | input | DATA_W | Value of the first source |
| iss_k_tag | input | TAG_W | Producer tag of the second source, 0 if the value is given |
| iss_k_val | input | DATA_W | Value of the second source |
| pool_full | output | 1 | All stations occupied; issue is not accepted |
| bc_valid | input | 1 | A result is on the shared bus |
| bc_tag | input | TAG_W | Tag of the producer of the broadcast result |
| bc_data | input | DATA_W | Broadcast result value |
| disp_valid | output | 1 | A station with both operands is offered |
| disp_ready | input | 1 | The functional unit takes the offered station |
| disp_op | output | OP_W | Operation code of the offered station |
| disp_a | output | DATA_W | First operand of the offered station |
| disp_b | output | DATA_W | Second operand of the offered station |
| disp_tag | output | TAG_W | Tag the result must carry on the bus |

## Verification
Several rules are checked on every cycle:
- at most one station is allocated and at most one is taken per cycle;
- a full pool stays full without a broadcast;
- an issue with both values present produces an offer in the next cycle;
- an unaccepted offer is held.

The rest can only be shown by the bench's scenarios:
- the exact values captured from the bus, including the same-cycle bypass at issue;
- the earliest-first order when that order differs from the station index;
- that an issue into a full pool leaves no trace;
- that a station is freed only by its own tag.

// File: rtl/rsv_pkg.sv
package rsv_pkg;

  // Life cycle of one station.
  typedef enum logic [1:0] {
    ST_FREE = 2'd0,  // available for allocation
    ST_HELD = 2'd1,  // holding an instruction, operands pending or complete
    ST_SENT = 2'd2   // taken by the unit, waiting for its own result tag
  } rsv_state_e;

endpackage

// File: rtl/rsv_entry.sv
module rsv_entry
  import rsv_pkg::*;
#(
  parameter int              DATA_W  = 64,
  parameter int              TAG_W   = 4,
  parameter int              OP_W    = 4,
  parameter logic [TAG_W-1:0] OWN_TAG = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc,
  input  logic              take,
  input  logic [OP_W-1:0]   iss_op,
  input  logic [TAG_W-1:0]  iss_j_tag,
  input  logic [DATA_W-1:0] iss_j_val,
  input  logic [TAG_W-1:0]  iss_k_tag,
  input  logic [DATA_W-1:0] iss_k_val,
  input  logic              bc_valid,
  input  logic [TAG_W-1:0]  bc_tag,
  input  logic [DATA_W-1:0] bc_data,
  output logic              busy,
  output logic              ready,
  output logic [OP_W-1:0]   op_q,
  output logic [DATA_W-1:0] j_val_q,
  output logic [DATA_W-1:0] k_val_q
);

  rsv_state_e        state_q, state_d;
  logic [TAG_W-1:0]  j_tag_q, j_tag_d, k_tag_q, k_tag_d;
  logic [DATA_W-1:0] j_val_d, k_val_d;
  logic              j_en, k_en;
  logic              hit_iss_j, hit_iss_k, hit_j, hit_k, own_hit;

  always_comb begin
    hit_iss_j = bc_valid && (iss_j_tag != '0) && (bc_tag == iss_j_tag);
    hit_iss_k = bc_valid && (iss_k_tag != '0) && (bc_tag == iss_k_tag);
    hit_j     = bc_valid && (j_tag_q != '0) && (bc_tag == j_tag_q);
    hit_k     = bc_valid && (k_tag_q != '0) && (bc_tag == k_tag_q);
    own_hit   = bc_valid && (bc_tag == OWN_TAG);
  end

  // next-state logic
  always_comb begin
    state_d = state_q;
    j_tag_d = j_tag_q;
    k_tag_d = k_tag_q;
    j_val_d = j_val_q;
    k_val_d = k_val_q;
    j_en    = 1'b0;
    k_en    = 1'b0;
    if (alloc) begin
      state_d = ST_HELD;
      j_en    = 1'b1;
      k_en    = 1'b1;
      j_tag_d = hit_iss_j ? '0 : iss_j_tag;
      j_val_d = hit_iss_j ? bc_data : iss_j_val;
      k_tag_d = hit_iss_k ? '0 : iss_k_tag;
      k_val_d = hit_iss_k ? bc_data : iss_k_val;
    end else begin
      case (state_q)
        ST_HELD: begin
          if (take) state_d = ST_SENT;
          if (hit_j) begin
            j_en    = 1'b1;
            j_tag_d = '0;
            j_val_d = bc_data;
          end
          if (hit_k) begin
            k_en    = 1'b1;
            k_tag_d = '0;
            k_val_d = bc_data;
          end
        end
        ST_SENT: if (own_hit) state_d = ST_FREE;
        default: state_d = state_q;
      endcase
    end
  end

  // control register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_FREE;
    else        state_q <= state_d;
  end

  // payload registers, enabled, not reset
  always_ff @(posedge clk) begin
    if (alloc) op_q <= iss_op;
    if (j_en) begin
      j_tag_q <= j_tag_d;
      j_val_q <= j_val_d;
    end
    if (k_en) begin
      k_tag_q <= k_tag_d;
      k_val_q <= k_val_d;
    end
  end

  assign busy  = (state_q != ST_FREE);
  assign ready = (state_q == ST_HELD) && (j_tag_q == '0) && (k_tag_q == '0);

endmodule

// File: rtl/rsv_alloc.sv
module rsv_alloc #(
  parameter int N_ENT = 4
) (
  input  logic [N_ENT-1:0] free_vec,
  output logic [N_ENT-1:0] grant,
  output logic             any_free
);

  always_comb begin
    logic found;
    found = 1'b0;
    grant = '0;
    for (int i = 0; i < N_ENT; i++) begin
      if (free_vec[i] && !found) begin
        grant[i] = 1'b1;
        found    = 1'b1;
      end
    end
    any_free = found;
  end

endmodule

// File: rtl/rsv_age_pick.sv
module rsv_age_pick #(
  parameter int N_ENT = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_ENT-1:0] alloc_vec,
  input  logic [N_ENT-1:0] rdy_vec,
  output logic [N_ENT-1:0] sel_vec,
  output logic             any_rdy
);

  // older_q[a][b] set: station a was issued before station b
  logic [N_ENT-1:0][N_ENT-1:0] older_q, older_d;
  logic                        older_en;

  always_comb begin
    older_d  = older_q;
    older_en = |alloc_vec;
    for (int j = 0; j < N_ENT; j++) begin
      if (alloc_vec[j]) begin
        for (int i = 0; i < N_ENT; i++) begin
          older_d[j][i] = 1'b0;
          older_d[i][j] = (i != j);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        older_q <= '0;
    else if (older_en) older_q <= older_d;
  end

  always_comb begin
    for (int i = 0; i < N_ENT; i++) begin
      logic blocked;
      blocked = 1'b0;
      for (int j = 0; j < N_ENT; j++) begin
        if ((j != i) && rdy_vec[j] && older_q[j][i]) blocked = 1'b1;
      end
      sel_vec[i] = rdy_vec[i] && !blocked;
    end
    any_rdy = |rdy_vec;
  end

endmodule

// File: rtl/rsv_pool.sv
module rsv_pool #(
  parameter int N_ENT    = 4,
  parameter int DATA_W   = 64,
  parameter int TAG_W    = 4,
  parameter int OP_W     = 4,
  parameter int TAG_BASE = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              iss_valid,
  input  logic [OP_W-1:0]   iss_op,
  input  logic [TAG_W-1:0]  iss_j_tag,
  input  logic [DATA_W-1:0] iss_j_val,
  input  logic [TAG_W-1:0]  iss_k_tag,
  input  logic [DATA_W-1:0] iss_k_val,
  output logic              pool_full,
  input  logic              bc_valid,
  input  logic [TAG_W-1:0]  bc_tag,
  input  logic [DATA_W-1:0] bc_data,
  output logic              disp_valid,
  input  logic              disp_ready,
  output logic [OP_W-1:0]   disp_op,
  output logic [DATA_W-1:0] disp_a,
  output logic [DATA_W-1:0] disp_b,
  output logic [TAG_W-1:0]  disp_tag
);

  localparam int TAG_LAST = TAG_BASE + N_ENT - 1;

  logic [N_ENT-1:0]             busy_vec, rdy_vec, grant, alloc_vec, sel_vec, take_vec;
  logic                         any_free, any_rdy;
  logic [N_ENT-1:0][OP_W-1:0]   op_arr;
  logic [N_ENT-1:0][DATA_W-1:0] a_arr, b_arr;

  rsv_alloc #(.N_ENT(N_ENT)) u_alloc (
    .free_vec (~busy_vec),
    .grant    (grant),
    .any_free (any_free)
  );

  assign alloc_vec = grant & {N_ENT{iss_valid}};
  assign pool_full = !any_free;

  rsv_age_pick #(.N_ENT(N_ENT)) u_pick (
    .clk       (clk),
    .rst_n     (rst_n),
    .alloc_vec (alloc_vec),
    .rdy_vec   (rdy_vec),
    .sel_vec   (sel_vec),
    .any_rdy   (any_rdy)
  );

  assign take_vec = sel_vec & {N_ENT{disp_ready}};

  for (genvar g = 0; g < N_ENT; g++) begin : g_ent
    rsv_entry #(
      .DATA_W  (DATA_W),
      .TAG_W   (TAG_W),
      .OP_W    (OP_W),
      .OWN_TAG (TAG_W'(TAG_BASE + g))
    ) u_ent (
      .clk       (clk),
      .rst_n     (rst_n),
      .alloc     (alloc_vec[g]),
      .take      (take_vec[g]),
      .iss_op    (iss_op),
      .iss_j_tag (iss_j_tag),
      .iss_j_val (iss_j_val),
      .iss_k_tag (iss_k_tag),
      .iss_k_val (iss_k_val),
      .bc_valid  (bc_valid),
      .bc_tag    (bc_tag),
      .bc_data   (bc_data),
      .busy      (busy_vec[g]),
      .ready     (rdy_vec[g]),
      .op_q      (op_arr[g]),
      .j_val_q   (a_arr[g]),
      .k_val_q   (b_arr[g])
    );
  end

  // one-hot output mux
  always_comb begin
    disp_op  = '0;
    disp_a   = '0;
    disp_b   = '0;
    disp_tag = '0;
    for (int i = 0; i < N_ENT; i++) begin
      if (sel_vec[i]) begin
        disp_op  = disp_op  | op_arr[i];
        disp_a   = disp_a   | a_arr[i];
        disp_b   = disp_b   | b_arr[i];
        disp_tag = disp_tag | TAG_W'(TAG_BASE + i);
      end
    end
    disp_valid = any_rdy && (TAG_LAST > 0);
  end

endmodule

// File: rtl/rsv_pool_chk.sv
module rsv_pool_chk #(
  parameter int N_ENT = 4,
  parameter int TAG_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             iss_valid,
  input logic [TAG_W-1:0] iss_j_tag,
  input logic [TAG_W-1:0] iss_k_tag,
  input logic             bc_valid,
  input logic             pool_full,
  input logic             disp_valid,
  input logic             disp_ready,
  input logic [N_ENT-1:0] alloc_vec,
  input logic [N_ENT-1:0] take_vec
);

  AST_ONE_ALLOC: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(alloc_vec)); // R2

  AST_FULL_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    pool_full && !bc_valid |=> pool_full); // R2

  AST_READY_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid && !pool_full && (iss_j_tag == '0) && (iss_k_tag == '0) |=> disp_valid); // R6

  AST_OFFER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid && !disp_ready |=> disp_valid); // R7

  AST_ONE_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(take_vec)); // R7

endmodule

bind rsv_pool rsv_pool_chk #(.N_ENT(N_ENT), .TAG_W(TAG_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .iss_valid  (iss_valid),
  .iss_j_tag  (iss_j_tag),
  .iss_k_tag  (iss_k_tag),
  .bc_valid   (bc_valid),
  .pool_full  (pool_full),
  .disp_valid (disp_valid),
  .disp_ready (disp_ready),
  .alloc_vec  (alloc_vec),
  .take_vec   (take_vec)
);

// File: tb/tb_rsv_pool.sv
module tb_rsv_pool;

  localparam int DATA_W = 64;
  localparam int TAG_W  = 4;
  localparam int OP_W   = 4;
  localparam int ITEM_W = OP_W + 2*DATA_W + TAG_W;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              iss_valid, bc_valid, disp_ready;
  logic [OP_W-1:0]   iss_op;
  logic [TAG_W-1:0]  iss_j_tag, iss_k_tag, bc_tag;
  logic [DATA_W-1:0] iss_j_val, iss_k_val, bc_data;
  logic              pool_full, disp_valid;
  logic [OP_W-1:0]   disp_op;
  logic [DATA_W-1:0] disp_a, disp_b;
  logic [TAG_W-1:0]  disp_tag;

  int n_chk  = 0;
  int n_fail = 0;
  logic [ITEM_W-1:0] exp_q[$];
  string             exp_req[$];

  always #4 clk = ~clk;  // 125 MHz

  rsv_pool dut (.*);

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic issue(input logic [3:0] op, input logic [3:0] jt, input logic [63:0] jv,
                       input logic [3:0] kt, input logic [63:0] kv);
    iss_valid = 1'b1; iss_op = op;
    iss_j_tag = jt; iss_j_val = jv; iss_k_tag = kt; iss_k_val = kv;
    step();
    iss_valid = 1'b0;
  endtask

  task automatic bcast(input logic [3:0] tag, input logic [63:0] data);
    bc_valid = 1'b1; bc_tag = tag; bc_data = data;
    step();
    bc_valid = 1'b0;
  endtask

  task automatic expect_disp(input logic [3:0] op, input logic [63:0] a, input logic [63:0] b,
                             input logic [3:0] tag, input string req);
    exp_q.push_back({op, a, b, tag});
    exp_req.push_back(req);
  endtask

  task automatic drain(input int n);
    disp_ready = 1'b1;
    repeat (n) step();
    disp_ready = 1'b0;
  endtask

  // monitor: compares every taken offer against the scoreboard
  initial begin
    forever begin
      @(negedge clk); #2;
      if (rst_n && disp_valid && disp_ready) begin
        logic [ITEM_W-1:0] got, want;
        string r;
        got = {disp_op, disp_a, disp_b, disp_tag};
        n_chk++;
        if (exp_q.size() == 0) begin
          n_fail++;
          $display("FAIL R7: actual unexpected offer %h expected none", got);
        end else begin
          want = exp_q.pop_front();
          r    = exp_req.pop_front();
          if (got !== want) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", r, got, want);
          end
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; iss_valid = 1'b0; bc_valid = 1'b0; disp_ready = 1'b0;
    iss_op = '0; iss_j_tag = '0; iss_k_tag = '0; iss_j_val = '0; iss_k_val = '0;
    bc_tag = '0; bc_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R1 full", 64'(pool_full), 64'd0);
    check("R1 valid", 64'(disp_valid), 64'd0);

    // both values present at issue
    issue(4'd1, 4'd0, 64'hA0A0, 4'd0, 64'hB0B0);
    check("R6 valid", 64'(disp_valid), 64'd1);
    check("R6 tag", 64'(disp_tag), 64'd1);
    check("R9 a", disp_a, 64'hA0A0);
    check("R9 b", disp_b, 64'hB0B0);
    expect_disp(4'd1, 64'hA0A0, 64'hB0B0, 4'd1, "R6");
    drain(1);
    check("R8 not reoffered", 64'(disp_valid), 64'd0);
    bcast(4'd1, 64'h0);

    // operands waiting on producer tags, multi-wake
    issue(4'd2, 4'd9, 64'h0, 4'd0, 64'h1111);
    issue(4'd3, 4'd0, 64'h2222, 4'd9, 64'h0);
    issue(4'd4, 4'd10, 64'h0, 4'd9, 64'h0);
    check("R3 waiting", 64'(disp_valid), 64'd0);
    bcast(4'd9, 64'hD9D9);
    check("R4 woke", 64'(disp_valid), 64'd1);
    check("R7 first", 64'(disp_tag), 64'd1);
    expect_disp(4'd2, 64'hD9D9, 64'h1111, 4'd1, "R4");
    expect_disp(4'd3, 64'h2222, 64'hD9D9, 4'd2, "R4");
    drain(2);
    check("R4 other tag waits", 64'(disp_valid), 64'd0);
    bcast(4'd10, 64'h1010);
    expect_disp(4'd4, 64'h1010, 64'hD9D9, 4'd3, "R4");
    drain(1);
    bcast(4'd1, 64'h0); bcast(4'd2, 64'h0); bcast(4'd3, 64'h0);

    // fill the pool
    for (int i = 0; i < 4; i++) issue(4'(5 + i), 4'd11, 64'h0, 4'd0, 64'h100 + 64'(i));
    check("R2 full", 64'(pool_full), 64'd1);
    issue(4'd9, 4'd0, 64'hDEAD, 4'd0, 64'hBEEF);
    bcast(4'd11, 64'hEEEE);
    for (int i = 0; i < 4; i++) expect_disp(4'(5 + i), 64'hEEEE, 64'h100 + 64'(i), 4'(1 + i), "R7");
    drain(4);
    check("R2 dropped issue", 64'(disp_valid), 64'd0);
    check("R8 sent stays busy", 64'(pool_full), 64'd1);
    bcast(4'd2, 64'h0);
    check("R8 freed", 64'(pool_full), 64'd0);
    issue(4'd10, 4'd12, 64'h0, 4'd0, 64'h5050);
    check("R2 lowest free", 64'(pool_full), 64'd1);
    bcast(4'd1, 64'h0);
    issue(4'd11, 4'd12, 64'h0, 4'd0, 64'h6060);
    bcast(4'd12, 64'h1212);
    check("R7 oldest not lowest", 64'(disp_tag), 64'd2);
    expect_disp(4'd10, 64'h1212, 64'h5050, 4'd2, "R7");
    expect_disp(4'd11, 64'h1212, 64'h6060, 4'd1, "R7");
    drain(2);
    bcast(4'd1, 64'h0); bcast(4'd2, 64'h0); bcast(4'd3, 64'h0); bcast(4'd4, 64'h0);

    // same-cycle bypass at issue
    iss_valid = 1'b1; iss_op = 4'd12;
    iss_j_tag = 4'd13; iss_j_val = 64'h0; iss_k_tag = 4'd0; iss_k_val = 64'h5A5A;
    bc_valid = 1'b1; bc_tag = 4'd13; bc_data = 64'hF00D;
    step();
    iss_valid = 1'b0; bc_valid = 1'b0;
    check("R5 valid", 64'(disp_valid), 64'd1);
    check("R5 value", disp_a, 64'hF00D);
    step(); step();
    check("R7 held", 64'(disp_valid), 64'd1);
    check("R7 held value", disp_a, 64'hF00D);
    expect_disp(4'd12, 64'hF00D, 64'h5A5A, 4'd1, "R5");
    drain(1);
    bcast(4'd1, 64'h0);
    check("R8 empty", 64'(pool_full | disp_valid), 64'd0);
    check("R7 scoreboard drained", 64'(exp_q.size()), 64'd0);

    summary();
    $finish;
  end

endmodule